// File: doc/BRIEF.md
# Crosspoint Routing Configuration Controller

This block is the digital control side of a crosspoint matrix with 16 inputs and 8 outputs. Routing words come in either as a serial bit stream or as 5-bit words written to one addressed output. Either path loads a single staging chain that holds one 5-bit field per output. Each field is a 4-bit input select plus an enable bit. An update strobe then moves the chain into holding latches. The latched words are decoded into 128 one-hot crosspoint connect lines and 8 output enables, which drive the analog switch fabric and the output buffers.

A serial output at the far end of the chain lets several controllers be chained from one serial source. A separate asynchronous active-low disable input turns every output off at once. It does not touch the staging chain or the latched selects.

The block runs on a system clock. The external shift clock is sampled on that clock and acts on its sampled falling edge. The active-high `rst` is synchronous and clears all state at power-up.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `out_en`, `xconn` and `sdo` are all 0.
- R2: With `ce_n` low and `par_mode` low, a shift happens at the first system clock edge where `sclk` is sampled 0 after being sampled 1. A shift moves `sdi` into the chain. Holding `sclk` low, or raising it, causes no further shift.
- R3: Output o owns chain bits [5o+4:5o]. Bits [3:0] are the input select and bit 4 is the enable. New bits enter at bit 0. In a full serial load of 40 bits, the first bit sent is output 7's enable and the last is output 0's select bit 0.
- R4: `sdo` presents the chain's top bit and changes only on serial shifts. A bit sent on `sdi` appears on `sdo` after 40 shifts. `sdo` holds during parallel writes.
- R5: With `ce_n` low and `par_mode` high, each sampled falling edge of `sclk` writes `pdata` (bits [3:0] select, bit 4 enable) into the field addressed by `paddr`. All other fields are unchanged.
- R6: While `ce_n` is high, shift clocks, parallel writes and `upd_n` have no effect on the chain, `sdo` or the latches.
- R7: While `upd_n` and `ce_n` are both sampled low, the latches copy the chain one system clock after the chain changes. While `upd_n` is high, the latches hold.
- R8: `dis_n` low clears every output enable at once, without waiting for a clock. The chain and the latched selects are kept, so a later update restores the former routing.
- R9: Connect line 16·o+i is high exactly when output o is enabled and its latched select equals i. A disabled output drives no connect line.
- R10: While `dis_n` stays low, an update cannot turn any output on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| sclk | input | 1 | Shift clock, acts on sampled falling edge |
| ce_n | input | 1 | Active-low enable for loading and transfer |
| par_mode | input | 1 | 0 = serial load, 1 = addressed parallel load |
| sdi | input | 1 | Serial data in |
| pdata | input | 5 | Parallel word: [3:0] select, [4] enable |
| paddr | input | 3 | Output addressed by a parallel write |
| upd_n | input | 1 | Active-low level-sensitive transfer to latches |
| dis_n | input | 1 | Asynchronous active-low disable of all outputs |
| sdo | output | 1 | Serial data out for chaining |
| out_en | output | 8 | Latched output enables |
| xconn | output | 128 | One-hot crosspoint connects, 16 per output |

## Verification
The bench sweeps every output address against every input select through parallel writes. This catches a wrong field offset or select decode, which would light the wrong connect line or disturb a neighbouring output. Full serial loads send more than 40 bits, with the low phase of the shift clock sometimes held for several cycles. A reversed stream order would scramble the routing, and edge detection that fires on a level would shift extra bits; either shows up in `sdo` and in the decoded routes. Further checks apply stimulus with `ce_n` high, drive `dis_n` low between clock edges, and hold `upd_n` low across writes. These expose a design that loads while deselected, waits for a clock to disable, lets an update override the disable, or lets the latches fail to follow or fail to hold.

// File: rtl/xbar_cfg_pkg.sv
`timescale 1ns/1ps
package xbar_cfg_pkg;
    localparam int NUM_OUT = 8;
    localparam int NUM_IN  = 16;
    localparam int SEL_W   = $clog2(NUM_IN);
    localparam int FIELD_W = SEL_W + 1;
    localparam int CHAIN_W = NUM_OUT * FIELD_W;
    localparam int ADDR_W  = $clog2(NUM_OUT);
    localparam int CONN_W  = NUM_OUT * NUM_IN;

    // enable sits in the field's top bit, select below it
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } route_t;

    typedef enum logic {
        LOAD_SERIAL   = 1'b0,
        LOAD_PARALLEL = 1'b1
    } load_mode_e;

    function automatic logic [NUM_IN-1:0] route_lines(input route_t r);
        logic [NUM_IN-1:0] v;
        v = '0;
        if (r.en) v[r.sel] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/xbar_cfg_stage.sv
`timescale 1ns/1ps
module xbar_cfg_stage
    import xbar_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                load_en,
    input  logic                sdi,
    input  route_t              wr_word,
    input  logic [ADDR_W-1:0]   wr_addr,
    output logic [CHAIN_W-1:0]  chain,
    output logic                sdo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            sdo   <= 1'b0;
        end else if (shift_en) begin
            chain <= {chain[CHAIN_W-2:0], sdi};
            sdo   <= chain[CHAIN_W-2];
        end else if (load_en) begin
            chain[wr_addr*FIELD_W +: FIELD_W] <= wr_word;
        end
    end
endmodule

// File: rtl/xbar_cfg_hold.sv
`timescale 1ns/1ps
module xbar_cfg_hold
    import xbar_cfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       dis_n,
    input  logic                       xfer,
    input  logic [CHAIN_W-1:0]         chain,
    output route_t [NUM_OUT-1:0]       held
);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        route_t           nxt;
        logic             en_q;
        logic [SEL_W-1:0] sel_q;

        assign nxt = route_t'(chain[o*FIELD_W +: FIELD_W]);

        // enable: asynchronous clear from the disable input
        always_ff @(posedge clk or negedge dis_n) begin
            if (!dis_n)    en_q <= 1'b0;
            else if (rst)  en_q <= 1'b0;
            else if (xfer) en_q <= nxt.en;
        end

        // select: untouched by the disable input
        always_ff @(posedge clk) begin
            if (rst)       sel_q <= '0;
            else if (xfer) sel_q <= nxt.sel;
        end

        assign held[o] = '{en: en_q, sel: sel_q};
    end
endmodule

// File: rtl/xbar_cfg_decode.sv
`timescale 1ns/1ps
module xbar_cfg_decode
    import xbar_cfg_pkg::*;
(
    input  route_t [NUM_OUT-1:0] held,
    output logic   [NUM_OUT-1:0] out_en,
    output logic   [CONN_W-1:0]  xconn
);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_dec
        assign out_en[o]                  = held[o].en;
        assign xconn[o*NUM_IN +: NUM_IN]  = route_lines(held[o]);
    end
endmodule

// File: rtl/xbar_cfg_ctrl.sv
`timescale 1ns/1ps
module xbar_cfg_ctrl
    import xbar_cfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sclk,
    input  logic                       ce_n,
    input  logic                       par_mode,
    input  logic                       sdi,
    input  logic [FIELD_W-1:0]         pdata,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic                       upd_n,
    input  logic                       dis_n,
    output logic                       sdo,
    output logic [NUM_OUT-1:0]         out_en,
    output logic [CONN_W-1:0]          xconn
);
    logic                 sclk_q;
    logic                 sclk_fall;
    logic                 active;
    load_mode_e           mode;
    logic                 shift_en;
    logic                 load_en;
    logic                 xfer;
    logic [CHAIN_W-1:0]   chain;
    route_t [NUM_OUT-1:0] held;

    // sampling flop for the external shift clock
    always_ff @(posedge clk) sclk_q <= sclk;

    assign sclk_fall = sclk_q & ~sclk;
    assign active    = sclk_fall & ~ce_n;
    assign mode      = load_mode_e'(par_mode);
    assign shift_en  = active & (mode == LOAD_SERIAL);
    assign load_en   = active & (mode == LOAD_PARALLEL);
    assign xfer      = ~upd_n & ~ce_n;

    xbar_cfg_stage i_stage (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .load_en  (load_en),
        .sdi      (sdi),
        .wr_word  (route_t'(pdata)),
        .wr_addr  (paddr),
        .chain    (chain),
        .sdo      (sdo)
    );

    xbar_cfg_hold i_hold (
        .clk   (clk),
        .rst   (rst),
        .dis_n (dis_n),
        .xfer  (xfer),
        .chain (chain),
        .held  (held)
    );

    xbar_cfg_decode i_dec (
        .held   (held),
        .out_en (out_en),
        .xconn  (xconn)
    );
endmodule

// File: rtl/xbar_cfg_chk.sv
`timescale 1ns/1ps
module xbar_cfg_chk
    import xbar_cfg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sclk,
    input logic               ce_n,
    input logic               par_mode,
    input logic               dis_n,
    input logic               sdo,
    input logic [NUM_OUT-1:0] out_en,
    input logic [CONN_W-1:0]  xconn
);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_o
        assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
            $onehot0(xconn[o*NUM_IN +: NUM_IN]));
        assert_en_match_R9: assert property (@(posedge clk) disable iff (rst)
            (|xconn[o*NUM_IN +: NUM_IN]) == out_en[o]);
    end

    assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
        !dis_n |-> (out_en == '0));

    assert_ce_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ce_n && dis_n && !rst) |=> (!dis_n || $stable(out_en)));

    assert_sdo_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && !($past(sclk) && !sclk && !ce_n && !par_mode)) |=> $stable(sdo));
endmodule

bind xbar_cfg_ctrl xbar_cfg_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .ce_n     (ce_n),
    .par_mode (par_mode),
    .dis_n    (dis_n),
    .sdo      (sdo),
    .out_en   (out_en),
    .xconn    (xconn)
);

// File: tb/test_xbar_cfg_ctrl.sv
`timescale 1ns/1ps
module test_xbar_cfg_ctrl;
    import xbar_cfg_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1;
    logic ce_n = 1'b1;
    logic par_mode = 1'b0;
    logic sdi = 1'b0;
    logic [4:0] pdata = '0;
    logic [2:0] paddr = '0;
    logic upd_n = 1'b1;
    logic dis_n = 1'b1;
    logic sdo;
    logic [7:0] out_en;
    logic [127:0] xconn;

    always #2.5 clk = ~clk;

    xbar_cfg_ctrl i_xbar_cfg_ctrl (
        .clk(clk), .rst(rst), .sclk(sclk), .ce_n(ce_n), .par_mode(par_mode),
        .sdi(sdi), .pdata(pdata), .paddr(paddr), .upd_n(upd_n), .dis_n(dis_n),
        .sdo(sdo), .out_en(out_en), .xconn(xconn)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [39:0] m_sr = '0;
    logic        m_sdo = 1'b0;
    logic [3:0]  m_sel [8];
    logic        m_en  [8];

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_routes(input string req);
        logic [7:0]   e_en;
        logic [127:0] e_cx;
        e_en = '0;
        e_cx = '0;
        for (int o = 0; o < 8; o++) begin
            e_en[o] = m_en[o];
            if (m_en[o]) e_cx[o*16 + int'(m_sel[o])] = 1'b1;
        end
        check(out_en == e_en, {req, " out_en"}, 128'(out_en), 128'(e_en));
        check(xconn == e_cx, {req, " xconn"}, xconn, e_cx);
    endtask

    // R2 R4: one serial bit, low phase held for 'hold' system clocks
    task automatic shift_bit(input bit b, input int hold);
        par_mode = 1'b0;
        sdi  = b;
        sclk = 1'b0;
        wait_n(hold);
        sclk = 1'b1;
        wait_n(1);
        if (!ce_n) begin
            m_sr  = {m_sr[38:0], b};
            m_sdo = m_sr[39];
        end
        check(sdo == m_sdo, "R4 sdo", 128'(sdo), 128'(m_sdo));
    endtask

    task automatic par_write(input int a, input logic [4:0] w);
        par_mode = 1'b1;
        paddr = 3'(a);
        pdata = w;
        sclk  = 1'b0;
        wait_n(1);
        sclk  = 1'b1;
        wait_n(1);
        if (!ce_n) m_sr[a*5 +: 5] = w;
        if (!ce_n && !upd_n) latch_model();
    endtask

    function automatic void latch_model();
        for (int o = 0; o < 8; o++) begin
            m_sel[o] = m_sr[o*5 +: 4];
            m_en[o]  = dis_n ? m_sr[o*5 + 4] : 1'b0;
        end
    endfunction

    task automatic update_pulse();
        upd_n = 1'b0;
        wait_n(1);
        upd_n = 1'b1;
        if (!ce_n) latch_model();
    endtask

    // R3: stream output 7 bit 4 first, output 0 bit 0 last
    task automatic serial_load(input logic [4:0] f [8], input int hold);
        for (int o = 7; o >= 0; o--)
            for (int d = 4; d >= 0; d--)
                shift_bit(f[o][d], hold);
    endtask

    initial begin
        logic [4:0] cfg [8];
        logic       sdo_before;
        for (int o = 0; o < 8; o++) begin m_sel[o] = '0; m_en[o] = 1'b0; end
        wait_n(3);
        check(out_en == 0 && xconn == 0 && sdo == 0, "R1 during reset", 128'(out_en), 0);
        rst = 1'b0;
        wait_n(1);
        check(out_en == 0 && xconn == 0 && sdo == 0, "R1 after reset", xconn, 0);
        ce_n = 1'b0;

        // serial load, then update
        for (int o = 0; o < 8; o++) cfg[o] = {1'(o % 3 != 1), 4'((o * 7 + 5) % 16)};
        serial_load(cfg, 1);
        check_routes("R7 hold before update");
        update_pulse();
        wait_n(1);
        check_routes("R3 serial routes");

        // second load with stretched low phase: sdo returns first stream
        for (int o = 0; o < 8; o++) cfg[o] = {1'(o % 2), 4'(15 - 2 * o)};
        serial_load(cfg, 3);
        update_pulse();
        check_routes("R2 stretched shift clock");

        // R6: deselected, nothing moves
        ce_n = 1'b1;
        sdo_before = sdo;
        for (int k = 0; k < 6; k++) shift_bit(1'b1, 1);
        par_write(2, 5'h1f);
        update_pulse();
        check_routes("R6 ce_n high");
        check(sdo == sdo_before, "R6 sdo", 128'(sdo), 128'(sdo_before));
        ce_n = 1'b0;
        update_pulse();
        check_routes("R6 chain unchanged");

        // R5 sweep: every address, every select
        for (int a = 0; a < 8; a++) begin
            for (int s = 0; s < 16; s++) begin
                sdo_before = sdo;
                par_write(a, {1'(s != a), 4'(s)});
                update_pulse();
                check_routes("R5 R9 parallel sweep");
                check(sdo == sdo_before, "R4 sdo held in parallel", 128'(sdo), 128'(sdo_before));
            end
        end

        // R7: transparent while upd_n low, then hold
        upd_n = 1'b0;
        wait_n(1);
        latch_model();
        par_write(4, 5'h19);
        check_routes("R7 transparent");
        par_write(1, 5'h13);
        check_routes("R7 transparent second");
        upd_n = 1'b1;
        wait_n(1);
        par_write(4, 5'h02);
        check_routes("R7 hold");

        // R8 R10: asynchronous disable
        update_pulse();
        wait_n(1);
        check_routes("R8 before disable");
        #1 dis_n = 1'b0;
        #0.5;
        check(out_en == 0 && xconn == 0, "R8 async clear", xconn, 0);
        for (int o = 0; o < 8; o++) m_en[o] = 1'b0;
        wait_n(1);
        update_pulse();
        check_routes("R10 update under disable");
        dis_n = 1'b1;
        wait_n(1);
        check_routes("R8 stays off after release");
        update_pulse();
        check_routes("R8 routing restored");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule